// File: doc/BRIEF.md
# Checkpoint-Gated Output Commit Buffer

This block sits on the path from a processor to its external devices and keeps every device write inside the chip until the execution that issued it has been confirmed free of faults. Writes enter from the processor side and are grouped into checkpoint intervals. A checkpoint pulse closes the interval that is open. A later commit pulse confirms the oldest closed interval, and only then are its writes released to the device port, in the order they were accepted.

When a fault is detected, the recovery logic pulses rollback. Every write that has not been committed is dropped, whether its interval is still open or closed and waiting for confirmation. Writes that are already committed keep draining, so no irreversible output is lost and no suspect output escapes. The capacity has to cover all the writes made during the confirmation delay. The processor side is held off with backpressure when the storage is full.

Top module: `obuf_commit_gate`

## Requirements
- R1: After reset the buffer is empty, `wr_ready_o` is 1 and `dev_valid_o` is 0.
- R2: A write whose interval is still open, or closed but not yet confirmed, never appears on the device port (`dev_valid_o` stays 0 for it).
- R3: `ckpt_i` closes the open interval at that clock edge. A write accepted in the same cycle as `ckpt_i` belongs to the interval being closed.
- R4: `commit_i` confirms the oldest closed interval. From the next cycle its entries are presented on the device port one per `dev_valid_o`/`dev_ready_i` handshake, in acceptance order, with the written address and data.
- R5: `rollback_i` discards every uncommitted entry, including a write accepted in the same cycle. The change is visible from the next cycle. Entries committed before the rollback still drain.
- R6: When `rollback_i` is high, a `commit_i` or `ckpt_i` in the same cycle is ignored.
- R7: A `commit_i` while no closed interval is pending has no effect.
- R8: The buffer holds DEPTH entries, committed but undrained ones included. `wr_ready_o` is 0 while it is full, and every accepted write is kept.
- R9: While `dev_valid_o` is 1 and `dev_ready_i` is 0, `dev_valid_o`, `dev_addr_o` and `dev_data_o` hold their values.
- R10: At most NMARK closed intervals wait for confirmation. A `ckpt_i` while NMARK are already waiting merges the open interval into the newest waiting one, so that interval is released by one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Processor write request |
| wr_ready_o | output | 1 | Space available; write accepted when both are high |
| wr_addr_i | input | ADDR_W | Device address of the write |
| wr_data_i | input | DATA_W | Write data |
| ckpt_i | input | 1 | Checkpoint boundary pulse, closes the open interval |
| commit_i | input | 1 | Confirms the oldest closed interval fault-free |
| rollback_i | input | 1 | Fault detected: drop all uncommitted writes |
| dev_valid_o | output | 1 | Committed write offered to the device |
| dev_ready_i | input | 1 | Device accepts the offered write |
| dev_addr_o | output | ADDR_W | Address of the offered write |
| dev_data_o | output | DATA_W | Data of the offered write |

## Verification
The hardest state to reach is a full buffer whose oldest entries are committed while the device stalls and newer entries are still unconfirmed. Reaching it needs a committed prefix that cannot leave and a suspect suffix that must be thrown away. The stimulus holds `dev_ready_i` low while it commits one interval and opens further ones, then rolls back. It checks that exactly the committed prefix drains afterwards. A second hard case is an overflow of the pending-interval queue, which needs NMARK+1 checkpoints with no commit in between. The bench then confirms the intervals one by one and checks how many entries each commit releases.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } obuf_entry_t;
endpackage

// File: rtl/obuf_ram.sv
module obuf_ram
  import obuf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        we_i,
  input  logic [IW-1:0] waddr_i,
  input  obuf_entry_t wdata_i,
  input  logic [IW-1:0] raddr_i,
  output obuf_entry_t rdata_o
);
  obuf_entry_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/obuf_marks.sv
module obuf_marks #(
  parameter int NMARK = 4,
  parameter int PW = 4,
  localparam int MW = $clog2(NMARK),
  localparam int CW = $clog2(NMARK + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [PW-1:0] val_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic          empty_o
);
  logic [PW-1:0] slot [NMARK];
  logic [MW-1:0] hd, tl;
  logic [CW-1:0] cnt;
  logic full, take, room, grow;

  assign full    = (cnt == CW'(NMARK));
  assign empty_o = (cnt == '0);
  assign take    = pop_i && !empty_o;
  assign room    = !full || take;
  assign grow    = push_i && room;
  assign head_o  = slot[hd];

  // full queue: the new boundary replaces the newest one (interval merge)
  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) begin
      if (room) slot[tl] <= val_i;
      else      slot[tl - MW'(1)] <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
    end else if (clr_i) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
    end else begin
      if (grow) tl <= tl + MW'(1);
      if (take) hd <= hd + MW'(1);
      cnt <= cnt + CW'(grow) - CW'(take);
    end
  end

  a_r10_mark_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(NMARK));
  a_r10_merge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i && !clr_i |=> cnt == CW'(NMARK));
  a_r5_marks_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/obuf_commit_gate.sv
module obuf_commit_gate
  import obuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NMARK = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ckpt_i,
  input  logic              commit_i,
  input  logic              rollback_i,
  output logic              dev_valid_o,
  input  logic              dev_ready_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_data_o
);
  logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr, used, mark_val, mark_head;
  logic full, wr_fire, dev_fire, mark_push, mark_pop, mark_empty, commit_take;
  obuf_entry_t wentry, rentry;

  assign used        = wr_ptr - rd_ptr;
  assign full        = (used == PW'(DEPTH));
  assign wr_ready_o  = !full;
  assign wr_fire     = wr_valid_i && wr_ready_o;
  assign dev_valid_o = (rd_ptr != cmt_ptr);
  assign dev_fire    = dev_valid_o && dev_ready_i;

  // boundary includes a write accepted in the same cycle
  assign mark_val    = wr_ptr + PW'(wr_fire);
  assign mark_push   = ckpt_i && !rollback_i;
  assign mark_pop    = commit_i && !rollback_i;
  assign commit_take = mark_pop && !mark_empty;

  assign wentry.addr = wr_addr_i;
  assign wentry.data = wr_data_i;
  assign dev_addr_o  = rentry.addr;
  assign dev_data_o  = rentry.data;

  obuf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .waddr_i (wr_ptr[IW-1:0]),
    .wdata_i (wentry),
    .raddr_i (rd_ptr[IW-1:0]),
    .rdata_o (rentry)
  );

  obuf_marks #(.NMARK(NMARK), .PW(PW)) u_marks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rollback_i),
    .push_i  (mark_push),
    .val_i   (mark_val),
    .pop_i   (mark_pop),
    .head_o  (mark_head),
    .empty_o (mark_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      if (rollback_i)   wr_ptr <= cmt_ptr;
      else if (wr_fire) wr_ptr <= wr_ptr + PW'(1);
      if (commit_take)  cmt_ptr <= mark_head;
      if (dev_fire)     rd_ptr <= rd_ptr + PW'(1);
    end
  end

  a_r8_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ptr - rd_ptr) <= PW'(DEPTH));
  a_r4_commit_within_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_ptr - rd_ptr) <= (wr_ptr - rd_ptr));
  a_r5_rollback_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollback_i |=> wr_ptr == $past(cmt_ptr));
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_valid_o && !dev_ready_i |=> dev_valid_o && $stable(dev_addr_o) && $stable(dev_data_o));
  a_r7_commit_only_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cmt_ptr));
endmodule

// File: tb/obuf_commit_gate_test.sv
`timescale 1ns/1ps
module obuf_commit_gate_test;
  localparam int DEPTH = 8;
  localparam int NMARK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid, wr_ready, ckpt, commit, rollback, dev_valid, dev_ready;
  logic [7:0]  wr_addr, dev_addr;
  logic [15:0] wr_data, dev_data;
  int checks = 0, fails = 0, sq = 0, cyc = 0;

  always #10 clk = ~clk;

  obuf_commit_gate #(.DEPTH(DEPTH), .NMARK(NMARK)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ckpt_i(ckpt), .commit_i(commit), .rollback_i(rollback),
    .dev_valid_o(dev_valid), .dev_ready_i(dev_ready),
    .dev_addr_o(dev_addr), .dev_data_o(dev_data)
  );

  function automatic logic [7:0] ea(int s);
    return 8'(s * 37 + 5);
  endfunction
  function automatic logic [15:0] ed(int s);
    return 16'((s * 259) ^ 16'hA5C3);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=completion", cyc);
      summary();
    end
  end

  task automatic put();
    wr_valid = 1'b1;
    wr_addr = ea(sq);
    wr_data = ed(sq);
    for (int g = 0; g < 1000 && !wr_ready; g++) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    sq++;
  endtask

  task automatic p_ckpt();
    ckpt = 1'b1; @(negedge clk); ckpt = 1'b0;
  endtask
  task automatic p_commit();
    commit = 1'b1; @(negedge clk); commit = 1'b0;
  endtask
  task automatic p_rollback();
    rollback = 1'b1; @(negedge clk); rollback = 1'b0;
  endtask

  task automatic quiet(input int c, input string req);
    dev_ready = 1'b1;
    for (int i = 0; i < c; i++) begin
      chk(!dev_valid, req, dev_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic drain(input int first, input int n, input bit stall, input string req);
    int k = 0;
    int g = 0;
    bit held = 0;
    logic [7:0] ha;
    logic [15:0] hd;
    while (k < n && g < 2000) begin
      dev_ready = stall ? ((g % 3) != 0) : 1'b1;
      if (held) begin
        chk(dev_valid && dev_addr == ha && dev_data == hd, "R9 stall hold", dev_data, hd);
        held = 0;
      end
      if (dev_valid) begin
        chk(dev_addr == ea(first + k) && dev_data == ed(first + k), req, dev_data, ed(first + k));
        if (dev_ready) k++;
        else begin
          held = 1; ha = dev_addr; hd = dev_data;
        end
      end
      @(negedge clk);
      g++;
    end
    dev_ready = 1'b1;
    chk(k == n, req, k, n);
    chk(!dev_valid, req, dev_valid, 0);
  endtask

  initial begin
    int base;
    wr_valid = 0; wr_addr = '0; wr_data = '0;
    ckpt = 0; commit = 0; rollback = 0; dev_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);
    chk(dev_valid == 1'b0, "R1 no output after reset", dev_valid, 0);

    // R2 held while open and while closed-unconfirmed, R4 ordered release
    base = sq;
    repeat (3) put();
    quiet(4, "R2 open interval held");
    p_ckpt();
    quiet(4, "R2 closed interval held");
    p_commit();
    drain(base, 3, 0, "R4 ordered release");

    // R4 sweep of every interval size up to capacity
    for (int n = 1; n <= DEPTH; n++) begin
      base = sq;
      repeat (n) put();
      p_ckpt();
      p_commit();
      drain(base, n, n[0], "R4 sweep release");
    end

    // R5 rollback keeps committed, drops closed and open uncommitted
    dev_ready = 1'b0;
    base = sq;
    repeat (2) put();
    p_ckpt();
    p_commit();
    repeat (2) put();
    p_ckpt();
    put();
    p_rollback();
    drain(base, 2, 0, "R5 committed survive rollback");
    quiet(3, "R5 uncommitted discarded");
    wr_valid = 1'b1; wr_addr = ea(sq); wr_data = ed(sq); rollback = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rollback = 1'b0; sq++;
    p_ckpt();
    p_commit();
    quiet(3, "R5 same-cycle write discarded");

    // R8 full buffer backpressure
    dev_ready = 1'b0;
    base = sq;
    repeat (DEPTH) put();
    wr_valid = 1'b1; wr_addr = ea(sq); wr_data = ed(sq);
    for (int i = 0; i < 3; i++) begin
      chk(wr_ready == 1'b0, "R8 full backpressure", wr_ready, 0);
      @(negedge clk);
    end
    wr_valid = 1'b0; sq++;
    chk(dev_valid == 1'b0, "R2 full but unconfirmed", dev_valid, 0);
    p_ckpt();
    p_commit();
    chk(wr_ready == 1'b0, "R8 committed entries occupy space", wr_ready, 0);
    drain(base, DEPTH, 1, "R8 full contents kept");
    chk(wr_ready == 1'b1, "R8 space freed", wr_ready, 1);

    // R7 commit with no pending interval
    p_commit();
    quiet(2, "R7 commit on empty");
    repeat (2) put();
    p_commit();
    quiet(3, "R7 commit with only open interval");
    p_rollback();

    // R10 marker queue overflow merges intervals
    base = sq;
    for (int i = 0; i < NMARK + 1; i++) begin
      put();
      p_ckpt();
    end
    for (int i = 0; i < NMARK - 1; i++) begin
      p_commit();
      drain(base + i, 1, 0, "R10 single interval release");
    end
    p_commit();
    drain(base + NMARK - 1, 2, 0, "R10 merged interval release");
    p_commit();
    quiet(3, "R10 nothing pending");

    // R3 write in checkpoint cycle joins the closing interval
    base = sq;
    put();
    wr_valid = 1'b1; wr_addr = ea(sq); wr_data = ed(sq); ckpt = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; ckpt = 1'b0; sq++;
    put();
    p_commit();
    drain(base, 2, 0, "R3 same-cycle write in closed interval");
    quiet(2, "R3 later write stays open");
    p_rollback();

    // R6 rollback priority
    repeat (2) put();
    p_ckpt();
    commit = 1'b1; rollback = 1'b1;
    @(negedge clk);
    commit = 1'b0; rollback = 1'b0;
    quiet(2, "R6 commit ignored under rollback");
    p_ckpt();
    p_commit();
    quiet(3, "R6 entries gone after rollback");
    put();
    ckpt = 1'b1; rollback = 1'b1;
    @(negedge clk);
    ckpt = 1'b0; rollback = 1'b0;
    p_commit();
    quiet(3, "R6 checkpoint ignored under rollback");
    base = sq;
    put();
    p_ckpt();
    p_commit();
    drain(base, 1, 0, "R6 normal after rollback");

    summary();
  end
endmodule